// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block tracks exceptions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction carries a small tag as it moves down the pipe: a valid bit, a 4-bit cause code and its PC. Fetch, decode, execute and memory can each raise a cause for the instruction they hold. The first cause recorded for an instruction is the one that stays with it. An exception is never taken where it is raised. It is taken only when the faulting instruction reaches writeback. At that point every younger instruction is squashed. The faulting PC and its cause are saved, and fetch is steered to a fixed handler address.

Because exceptions are resolved in program order at the last stage, an older instruction's fault always wins over a younger one. This holds even when the younger fault was raised earlier in time. State writes are gated so that nothing from the faulting instruction onward changes the register file or data memory.

External interrupt requests are handled differently. They are latched, and fetch is held while the pipe drains. Once every stage is empty, fetch is steered to a separate interrupt address, and the PC that fetch was holding is saved as the resume point.

Top module: `exc_ctrl`

## Requirements
- R1: After synchronous reset, all stage valid bits, `epc`, `ecause`, `redirect`, `fetch_hold`, `mem_wr_en` and `reg_wr_en` are 0.
- R2: Cause encoding is as follows: 0 none, 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 arithmetic overflow, 6 data page fault, 7 data misaligned, 8 data protection, 9 memory error, 10 interrupt. An instruction keeps the first nonzero cause raised for it. Later stages cannot overwrite it.
- R3: For a faulting instruction fetched in cycle N, `redirect` is 1 in cycle N+4, while the instruction sits in writeback. `redirect` stays 0 for instructions without a cause.
- R4: When a fault is taken, `redirect_pc` equals HANDLER_PC. At the next edge, `epc` takes the instruction's PC, `ecause` takes its code, and all stage valid bits clear, which also discards an instruction fetched in that same cycle. `epc` changes on no other cycle.
- R5: When two instructions both fault, the older one's cause and PC are the ones saved, and the younger instruction's fault is never taken.
- R6: `mem_wr_en` follows `mem_wr_req` only when the memory-stage instruction is valid, carries no cause, raises no memory fault this cycle, and writeback is not taking a fault.
- R7: `reg_wr_en` follows `wb_reg_wr_req` only when the writeback instruction is valid and carries no cause. An overflow therefore blocks its own register write.
- R8: A pulse on `irq_req` is latched. From the next cycle on, `fetch_hold` is 1 and `if_vld` is ignored. Once all four stage valid bits are 0, `redirect` is 1 with `redirect_pc` equal to IRQ_PC. At the next edge, `epc` takes `if_pc`, `ecause` becomes 10, and `fetch_hold` drops.
- R9: If a fault reaches writeback while an interrupt is pending, the fault is taken first. The interrupt is taken in the following empty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_vld | input | 1 | An instruction is fetched this cycle |
| if_pc | input | 32 | PC of the fetched instruction, or the held fetch PC |
| if_cause | input | 4 | Fetch-stage cause (0, 1, 2 or 3) |
| id_illegal | input | 1 | Decode finds an undefined opcode |
| ex_overflow | input | 1 | Execute reports arithmetic overflow |
| mem_cause | input | 4 | Memory-stage cause (0 or 6 to 9) |
| mem_wr_req | input | 1 | Memory-stage instruction wants to write data memory |
| wb_reg_wr_req | input | 1 | Writeback instruction wants to write a register |
| irq_req | input | 1 | External interrupt request pulse |
| fetch_hold | output | 1 | Fetch must stall (interrupt drain) |
| redirect | output | 1 | Fetch must jump to `redirect_pc` |
| redirect_pc | output | 32 | Handler or interrupt address |
| epc | output | 32 | Saved exception PC |
| ecause | output | 4 | Saved cause code |
| mem_wr_en | output | 1 | Data-memory write permitted |
| reg_wr_en | output | 1 | Register write permitted |
| stage_vld | output | 4 | Valid bits of decode, execute, memory and writeback (bit 0 is decode) |

## Verification
The bench targets four corner cases.

- **Several causes on one instruction.** An instruction collects a fetch, decode, overflow and memory cause at once. A design that let later stages overwrite the cause would report 6 instead of 3.
- **Out-of-order faults.** An older memory fault is raised after a younger fetch fault. A design that took faults where they are raised would save the younger PC.
- **Write gating behind a trap.** A clean younger store sits in the memory stage while the trap is in writeback. A design without this gating would let that store through.
- **Interrupt and fault together.** An interrupt is pending while a fault drains. A design that got the priority wrong would save the interrupt's cause and lose the fault, or redirect before the pipe is empty.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PC_W    = 32;
    localparam int CAUSE_W = 4;
    localparam int NSTG    = 4;   // decode, execute, memory, writeback registers

    typedef enum logic [CAUSE_W-1:0] {
        EXC_NONE      = 4'd0,
        EXC_IF_PAGE   = 4'd1,
        EXC_IF_ALIGN  = 4'd2,
        EXC_IF_PROT   = 4'd3,
        EXC_ID_OPC    = 4'd4,
        EXC_EX_OVF    = 4'd5,
        EXC_MEM_PAGE  = 4'd6,
        EXC_MEM_ALIGN = 4'd7,
        EXC_MEM_PROT  = 4'd8,
        EXC_MEM_ERR   = 4'd9,
        EXC_IRQ       = 4'd10
    } exc_cause_e;

    typedef struct packed {
        logic            vld;
        exc_cause_e      cause;
        logic [PC_W-1:0] pc;
    } stage_tag_t;

    // Attach a newly raised cause unless one is already recorded.
    function automatic stage_tag_t merge_tag(stage_tag_t t, exc_cause_e raised);
        stage_tag_t r;
        r = t;
        if (!t.vld)
            r.cause = EXC_NONE;
        else if (t.cause == EXC_NONE)
            r.cause = raised;
        return r;
    endfunction

    function automatic logic is_fault(stage_tag_t t);
        return t.vld && (t.cause != EXC_NONE);
    endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  stage_tag_t d,
    input  exc_cause_e raised,
    output stage_tag_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush)
            q <= '0;
        else
            q <= merge_tag(d, raised);
    end

    AST_FIRST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (d.vld && d.cause != EXC_NONE && !flush) |=> (q.cause == $past(d.cause))); // R2

    AST_RAISE_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (d.vld && d.cause == EXC_NONE && !flush) |=> (q.cause == $past(raised))); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> !q.vld); // R4

endmodule

// File: rtl/exc_write_gate.sv
module exc_write_gate
    import exc_pkg::*;
(
    input  stage_tag_t mem_tag,
    input  exc_cause_e mem_raised,
    input  stage_tag_t wb_tag,
    input  logic       wb_trap,
    input  logic       mem_wr_req,
    input  logic       wb_reg_wr_req,
    output logic       mem_wr_en,
    output logic       reg_wr_en
);

    logic mem_clean;

    always_comb begin
        mem_clean = mem_tag.vld && (mem_tag.cause == EXC_NONE) && (mem_raised == EXC_NONE);
        mem_wr_en = mem_wr_req && mem_clean && !wb_trap;
        reg_wr_en = wb_reg_wr_req && wb_tag.vld && (wb_tag.cause == EXC_NONE);
    end

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
    parameter logic [PC_W-1:0] IRQ_PC     = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst,
    input  stage_tag_t      wb_tag,
    input  logic            pipe_empty,
    input  logic            irq_req,
    input  logic [PC_W-1:0] if_pc,
    output logic            take_fault,
    output logic            take_irq,
    output logic            fetch_hold,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] epc,
    output exc_cause_e      ecause
);

    logic irq_pend;

    always_comb begin
        take_fault  = is_fault(wb_tag);
        take_irq    = irq_pend && pipe_empty && !take_fault;
        fetch_hold  = irq_pend;
        redirect    = take_fault || take_irq;
        redirect_pc = take_fault ? HANDLER_PC : (take_irq ? IRQ_PC : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend <= 1'b0;
            epc      <= '0;
            ecause   <= EXC_NONE;
        end else begin
            irq_pend <= irq_req || (irq_pend && !take_irq);
            if (take_fault) begin
                epc    <= wb_tag.pc;
                ecause <= wb_tag.cause;
            end else if (take_irq) begin
                epc    <= if_pc;
                ecause <= EXC_IRQ;
            end
        end
    end

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> $stable(epc) && $stable(ecause)); // R4

    AST_FAULT_SAVED: assert property (@(posedge clk) disable iff (rst)
        take_fault |=> (epc == $past(wb_tag.pc))); // R4

    AST_FAULT_OVER_IRQ: assert property (@(posedge clk) disable iff (rst)
        (take_fault && irq_pend) |=> irq_pend); // R9

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
    parameter logic [PC_W-1:0] IRQ_PC     = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               if_vld,
    input  logic [PC_W-1:0]    if_pc,
    input  logic [CAUSE_W-1:0] if_cause,
    input  logic               id_illegal,
    input  logic               ex_overflow,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  logic               mem_wr_req,
    input  logic               wb_reg_wr_req,
    input  logic               irq_req,
    output logic               fetch_hold,
    output logic               redirect,
    output logic [PC_W-1:0]    redirect_pc,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] ecause,
    output logic               mem_wr_en,
    output logic               reg_wr_en,
    output logic [NSTG-1:0]    stage_vld
);

    localparam int MEM_IDX = NSTG - 1;
    localparam int WB_IDX  = NSTG;

    stage_tag_t tag   [0:NSTG];
    exc_cause_e raise [0:NSTG-1];
    logic       take_fault, take_irq, pipe_empty;
    exc_cause_e ecause_e;

    assign tag[0]   = '{vld: if_vld && !fetch_hold, cause: EXC_NONE, pc: if_pc};
    assign raise[0] = exc_cause_e'(if_cause);
    assign raise[1] = id_illegal  ? EXC_ID_OPC : EXC_NONE;
    assign raise[2] = ex_overflow ? EXC_EX_OVF : EXC_NONE;
    assign raise[3] = exc_cause_e'(mem_cause);

    genvar gi;
    generate
        for (gi = 0; gi < NSTG; gi++) begin : g_stage
            exc_stage_reg u_reg (
                .clk    (clk),
                .rst    (rst),
                .flush  (redirect),
                .d      (tag[gi]),
                .raised (raise[gi]),
                .q      (tag[gi+1])
            );
            assign stage_vld[gi] = tag[gi+1].vld;
        end
    endgenerate

    assign pipe_empty = (stage_vld == '0);

    exc_commit #(
        .HANDLER_PC (HANDLER_PC),
        .IRQ_PC     (IRQ_PC)
    ) u_commit (
        .clk         (clk),
        .rst         (rst),
        .wb_tag      (tag[WB_IDX]),
        .pipe_empty  (pipe_empty),
        .irq_req     (irq_req),
        .if_pc       (if_pc),
        .take_fault  (take_fault),
        .take_irq    (take_irq),
        .fetch_hold  (fetch_hold),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .epc         (epc),
        .ecause      (ecause_e)
    );

    assign ecause = ecause_e;

    exc_write_gate u_gate (
        .mem_tag       (tag[MEM_IDX]),
        .mem_raised    (raise[MEM_IDX]),
        .wb_tag        (tag[WB_IDX]),
        .wb_trap       (take_fault),
        .mem_wr_req    (mem_wr_req),
        .wb_reg_wr_req (wb_reg_wr_req),
        .mem_wr_en     (mem_wr_en),
        .reg_wr_en     (reg_wr_en)
    );

    AST_NO_STORE_BEHIND_TRAP: assert property (@(posedge clk) disable iff (rst)
        take_fault |-> !mem_wr_en); // R6

    AST_NO_REGWR_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !reg_wr_en); // R7

    AST_IRQ_ON_EMPTY_PIPE: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (stage_vld == '0)); // R8

    AST_HOLD_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_hold |=> !stage_vld[0]); // R8

    AST_ONE_REDIRECT_KIND: assert property (@(posedge clk) disable iff (rst)
        !(take_fault && take_irq)); // R9

endmodule

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
    import exc_pkg::*;

    localparam logic [31:0] HPC = 32'h0000_0080;
    localparam logic [31:0] IPC = 32'h0000_0100;
    localparam int NVEC = 10;

    // {fetch cause[13:10], illegal[9], overflow[8], mem cause[7:4], expected cause[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 1'b0, 4'd0, 4'd0},
        {4'd1, 1'b0, 1'b0, 4'd0, 4'd1},
        {4'd2, 1'b0, 1'b0, 4'd0, 4'd2},
        {4'd3, 1'b1, 1'b1, 4'd6, 4'd3},
        {4'd0, 1'b1, 1'b0, 4'd0, 4'd4},
        {4'd0, 1'b0, 1'b1, 4'd7, 4'd5},
        {4'd0, 1'b0, 1'b0, 4'd8, 4'd8},
        {4'd0, 1'b0, 1'b0, 4'd9, 4'd9},
        {4'd0, 1'b1, 1'b1, 4'd0, 4'd4},
        {4'd0, 1'b0, 1'b0, 4'd6, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        if_vld = 1'b0;
    logic [31:0] if_pc = '0;
    logic [3:0]  if_cause = '0;
    logic        id_illegal = 1'b0;
    logic        ex_overflow = 1'b0;
    logic [3:0]  mem_cause = '0;
    logic        mem_wr_req = 1'b0;
    logic        wb_reg_wr_req = 1'b0;
    logic        irq_req = 1'b0;
    logic        fetch_hold, redirect, mem_wr_en, reg_wr_en;
    logic [31:0] redirect_pc, epc;
    logic [3:0]  ecause, stage_vld;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    exc_ctrl #(.HANDLER_PC(HPC), .IRQ_PC(IPC)) u0 (
        .clk(clk), .rst(rst), .if_vld(if_vld), .if_pc(if_pc), .if_cause(if_cause),
        .id_illegal(id_illegal), .ex_overflow(ex_overflow), .mem_cause(mem_cause),
        .mem_wr_req(mem_wr_req), .wb_reg_wr_req(wb_reg_wr_req), .irq_req(irq_req),
        .fetch_hold(fetch_hold), .redirect(redirect), .redirect_pc(redirect_pc),
        .epc(epc), .ecause(ecause), .mem_wr_en(mem_wr_en), .reg_wr_en(reg_wr_en),
        .stage_vld(stage_vld)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        if_vld = 0; if_cause = 0; id_illegal = 0; ex_overflow = 0;
        mem_cause = 0; mem_wr_req = 0; wb_reg_wr_req = 0; irq_req = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev_epc;
        logic [3:0]  prev_cause;

        repeat (3) cyc();
        rst = 0;
        #1;
        // R1 reset state
        check("R1 stage_vld", 32'(stage_vld), 0);
        check("R1 epc", epc, 0);
        check("R1 ecause", 32'(ecause), 0);
        check("R1 redirect", 32'(redirect), 0);
        check("R1 fetch_hold", 32'(fetch_hold), 0);
        check("R1 write enables", {30'd0, mem_wr_en, reg_wr_en}, 0);
        prev_epc = 0; prev_cause = 0;

        // Table walk: one instruction per vector, causes raised stage by stage
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  fc, mc, ex;
            logic        ill, ovf;
            logic [31:0] pc;
            {fc, ill, ovf, mc, ex} = VEC[i];
            pc = 32'h1000 + 32'(i) * 4;
            cyc(); idle_inputs(); if_vld = 1; if_pc = pc; if_cause = fc;
            cyc(); idle_inputs(); id_illegal = ill;
            cyc(); idle_inputs(); ex_overflow = ovf;
            cyc(); idle_inputs(); mem_cause = mc; mem_wr_req = 1; #1;
            check("R6 mem_wr_en", 32'(mem_wr_en), 32'(ex == 0));
            cyc(); idle_inputs(); wb_reg_wr_req = 1; #1;
            check("R3 redirect at writeback", 32'(redirect), 32'(ex != 0));
            if (ex != 0) check("R4 handler pc", redirect_pc, HPC);
            check("R7 reg_wr_en", 32'(reg_wr_en), 32'(ex == 0));
            cyc(); idle_inputs(); #1;
            if (ex != 0) begin prev_epc = pc; prev_cause = ex; end
            check("R2 ecause first cause", 32'(ecause), 32'(prev_cause));
            check("R4 epc", epc, prev_epc);
            check("R4 pipe empty", 32'(stage_vld), 0);
        end

        // R5/R6: older memory fault beats younger fetch fault; store behind trap blocked
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h2000;               // A
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h2004;               // B clean
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h2008; if_cause = 1; // C faults early
        cyc(); idle_inputs(); mem_cause = 6; mem_wr_req = 1; #1;          // A in memory
        check("R6 own memory fault blocks store", 32'(mem_wr_en), 0);
        check("R3 no early redirect", 32'(redirect), 0);
        cyc(); idle_inputs(); mem_wr_req = 1; if_vld = 1; if_pc = 32'h200c; #1; // A in writeback
        check("R5 older fault taken", 32'(redirect), 1);
        check("R6 store behind trap blocked", 32'(mem_wr_en), 0);
        cyc(); idle_inputs(); #1;
        check("R5 ecause of older", 32'(ecause), 6);
        check("R5 epc of older", epc, 32'h2000);
        check("R4 younger and same-cycle fetch squashed", 32'(stage_vld), 0);
        for (int k = 0; k < 4; k++) begin
            cyc(); #1;
            check("R5 younger fault never taken", 32'(redirect), 0);
        end

        // R8: interrupt drains the pipe
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h3000;               // A cycle0
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h3004; irq_req = 1;  // B cycle1
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h3008; #1;           // cycle2, held
        check("R8 fetch_hold", 32'(fetch_hold), 1);
        check("R8 no redirect while draining", 32'(redirect), 0);
        cyc(); idle_inputs(); if_vld = 1; #1;                             // cycle3
        check("R8 held fetch ignored", 32'(stage_vld[0]), 0);
        check("R8 no redirect while draining", 32'(redirect), 0);
        cyc(); #1;                                                        // cycle4
        check("R8 no redirect while draining", 32'(redirect), 0);
        cyc(); #1;                                                        // cycle5: B in writeback
        check("R8 no redirect while draining", 32'(redirect), 0);
        cyc(); #1;                                                        // cycle6: empty
        check("R8 irq redirect", 32'(redirect), 1);
        check("R8 irq address", redirect_pc, IPC);
        cyc(); idle_inputs(); #1;
        check("R8 irq cause", 32'(ecause), 10);
        check("R8 irq resume pc", epc, 32'h3008);
        check("R8 hold released", 32'(fetch_hold), 0);

        // R9: fault in flight beats pending interrupt
        cyc(); idle_inputs(); if_vld = 1; if_pc = 32'h4000; if_cause = 2;
        cyc(); idle_inputs(); irq_req = 1; if_pc = 32'h4004;
        cyc(); idle_inputs();
        cyc();
        cyc(); #1;
        check("R9 fault first", 32'(redirect), 1);
        check("R9 handler address", redirect_pc, HPC);
        cyc(); #1;
        check("R9 fault cause saved", 32'(ecause), 2);
        check("R9 irq follows", 32'(redirect), 1);
        check("R9 irq address", redirect_pc, IPC);
        cyc(); #1;
        check("R9 irq cause", 32'(ecause), 10);
        check("R9 irq resume pc", epc, 32'h4004);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule